// File: doc/BRIEF.md
# Receive Elastic Buffer with Gated Playout Clock

The block sits on the receive side of a burst-mode serial link. Decoded bits arrive in groups of three, in irregular bursts with idle gaps between them. They are written into a small bit-wide circular store. A programmable divider then plays them out one at a time on `rx_data` with a companion clock `rx_clk`. Each bit is launched at the start of its period. The clock rises half a period later, so the receiver sees stable data on every rising edge.

The clock is gated: when the store holds no bits, `rx_clk` stays low. Every rising edge therefore carries a real bit, and packets with gaps between them come out cleanly. A small fill-tracking loop counts played bits in windows. At the end of each window it compares the fill level with half-full and stretches or shrinks the next bit period by one tick. This keeps the mean playout rate equal to the far-end rate.

The window starts at 256 bits and doubles each time a window passes without a correction, so a well-matched pair of clocks is trimmed rarely. In asynchronous mode the clock output is held low while the data keeps flowing.

The playout controller has three states:
- `PH_IDLE`: store empty, clock low. It goes to `PH_LOW` with a pop when the store is not empty.
- `PH_LOW`: a bit is launched and the clock is low. It goes to `PH_HIGH` when the low count expires.
- `PH_HIGH`: the clock is high. When the high count expires it goes to `PH_LOW` with a pop if bits remain, otherwise to `PH_IDLE`.

The trim controller holds a pending correction in one of three states: `TRIM_NONE`, `TRIM_SHORT` or `TRIM_LONG`. It is set at a window end and returns to `TRIM_NONE` at the next bit start, which consumes it.

Top module: `rx_elastic_buf`

## Requirements
- R1: A synchronous reset empties the store, forces `rx_clk` and `rx_data` low, and cancels any pending correction. After reset no clock edge appears until new bits are written.
- R2: When `wr_valid` is high, the three bits on `wr_bits` are stored as one group, and `wr_bits[0]` is played first. The group is stored only if the free space (32 minus the fill at the start of that cycle) is at least 3. Otherwise the whole group is dropped.
- R3: Bits leave in the order written, one per bit period. `rx_data` changes only at the start of a period and is stable while `rx_clk` is high.
- R4: `rx_clk` never rises unless a stored bit is being played. It stays low while the store is empty, and playout resumes on its own when bits arrive after a gap.
- R5: The bit period is P = max(`div_cfg`, 4) clock cycles. Of these, floor(P/2) cycles are clock-low and the rest clock-high.
- R6: When `async_mode` is high, `rx_clk` is held low while bits still play out on `rx_data` with normal timing.
- R7: The bit that ends a window is checked using the fill at its start. A fill of 19 or more shortens the next bit period by one cycle. A fill of 13 or less lengthens it by one cycle. Any other fill gives no change.
- R8: The first window after reset is 256 bits. A window that ends with no correction doubles the next window, up to 2048 bits. A correction returns the window to 256 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| async_mode | input | 1 | High: hold the playout clock off |
| div_cfg | input | 8 | Nominal bit period in clock cycles (minimum 4) |
| wr_valid | input | 1 | Write strobe for one three-bit group |
| wr_bits | input | 3 | Group of decoded bits, bit 0 first |
| rx_data | output | 1 | Serial playout data |
| rx_clk | output | 1 | Gated playout clock, rises mid-bit |

## Verification
If a read pointer or fill count is corrupted, the next rising edge of `rx_clk` carries a bit out of order. A clock edge can also appear with nothing behind it. The scoreboard catches either within one bit period. A wrong window length or wrong decision in the trim loop shows up as one clock interval, one tick too long or too short, at the wrong edge number. Because the expected edge numbers are exact, such a fault is caught at the first window end, within a few thousand bits. A gating fault shows as an edge during a gap or in asynchronous mode, and is caught within one period.

// File: rtl/rxeb_pkg.sv
package rxeb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_t;

    typedef enum logic [1:0] {
        TRIM_NONE,
        TRIM_SHORT,
        TRIM_LONG
    } trim_t;

endpackage

// File: rtl/rxeb_fifo.sv
module rxeb_fifo #(
    parameter int DEPTH = 32,
    parameter int CHUNK = 3,
    parameter int FW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [CHUNK-1:0] wr_bits,
    input  logic             pop,
    output logic             rd_bit,
    output logic [FW-1:0]    fill
);
    localparam int AW  = $clog2(DEPTH);
    localparam int CHW = (CHUNK > 1) ? $clog2(CHUNK) : 1;

    logic          mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          accept;
    logic [FW-1:0] fill_nxt;

    // room is judged on the fill held at the start of the cycle
    assign accept   = wr_valid && ((FW'(DEPTH) - fill) >= FW'(CHUNK));
    assign fill_nxt = fill + (accept ? FW'(CHUNK) : FW'(0)) - (pop ? FW'(1) : FW'(0));
    assign rd_bit   = mem[rd_ptr];

    // per-slot write: slot k takes bit (k - wr_ptr) of the group when in range
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        logic [AW-1:0] off;
        assign off = AW'(k) - wr_ptr;
        always_ff @(posedge clk) begin
            if (accept && (off < AW'(CHUNK))) begin
                mem[k] <= wr_bits[off[CHW-1:0]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (accept) begin
                wr_ptr <= wr_ptr + AW'(CHUNK);
            end
            if (pop) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            fill <= fill_nxt;
        end
    end

    // R2: the fill count never exceeds the store size
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= FW'(DEPTH))
        else $error("fill above depth");

    // R4: the playout side never pops an empty store
    a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> (fill != '0))
        else $error("pop while empty");

endmodule

// File: rtl/rxeb_trim.sv
module rxeb_trim
    import rxeb_pkg::*;
#(
    parameter int DEPTH      = 32,
    parameter int FW         = $clog2(DEPTH + 1),
    parameter int WIN_MIN    = 256,
    parameter int WIN_SHIFTS = 3,
    parameter int DEADBAND   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_start,
    input  logic [FW-1:0] fill,
    output trim_t         trim
);
    localparam int WIN_MAX = WIN_MIN << WIN_SHIFTS;
    localparam int CNTW    = $clog2(WIN_MAX + 1);
    localparam int HALF    = DEPTH / 2;
    localparam int HI_TH   = HALF + DEADBAND;
    localparam int LO_TH   = HALF - DEADBAND;

    logic [CNTW-1:0] bit_cnt;
    logic [CNTW-1:0] win;
    logic [CNTW-1:0] cnt_inc;
    logic            at_end;
    trim_t           pend;
    trim_t           verdict;

    assign trim    = pend;
    assign cnt_inc = bit_cnt + CNTW'(1);
    assign at_end  = (cnt_inc == win);

    always_comb begin
        if (fill >= FW'(HI_TH)) begin
            verdict = TRIM_SHORT;
        end else if (fill <= FW'(LO_TH)) begin
            verdict = TRIM_LONG;
        end else begin
            verdict = TRIM_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            win     <= CNTW'(WIN_MIN);
            pend    <= TRIM_NONE;
        end else if (bit_start) begin
            if (at_end) begin
                bit_cnt <= '0;
                pend    <= verdict;
                if (verdict != TRIM_NONE) begin
                    win <= CNTW'(WIN_MIN);
                end else if (win >= CNTW'(WIN_MAX)) begin
                    win <= CNTW'(WIN_MAX);
                end else begin
                    win <= win << 1;
                end
            end else begin
                bit_cnt <= cnt_inc;
                pend    <= TRIM_NONE;
            end
        end
    end

    // R8: window is always a power-of-two multiple of the minimum, within the cap
    a_r8_window_range: assert property (@(posedge clk) disable iff (rst)
        ($countones(win) == 1) && (win >= CNTW'(WIN_MIN)) && (win <= CNTW'(WIN_MAX)))
        else $error("window out of range");

    // R7: a pending correction is used by exactly one bit
    a_r7_single_tick: assert property (@(posedge clk) disable iff (rst)
        (bit_start && (pend != TRIM_NONE)) |=> (pend == TRIM_NONE))
        else $error("correction applied twice");

endmodule

// File: rtl/rxeb_playout.sv
module rxeb_playout
    import rxeb_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             async_mode,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic             empty,
    input  logic             rd_bit,
    input  trim_t            trim,
    output logic             pop,
    output logic             rx_data,
    output logic             rx_clk
);
    phase_t           state, nxt;
    logic [DIV_W-1:0] cnt, cnt_n;
    logic [DIV_W-1:0] hi_q, hi_n;
    logic [DIV_W-1:0] period;
    logic [DIV_W-1:0] lo_base;
    logic [DIV_W-1:0] lo_len;
    logic [DIV_W-1:0] hi_len;

    assign period  = (div_cfg < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_cfg;
    assign lo_base = period >> 1;
    assign hi_len  = period - lo_base;

    always_comb begin
        unique case (trim)
            TRIM_SHORT: lo_len = lo_base - DIV_W'(1);
            TRIM_LONG:  lo_len = lo_base + DIV_W'(1);
            default:    lo_len = lo_base;
        endcase
    end

    // next-state and output decode
    always_comb begin
        nxt   = state;
        cnt_n = cnt;
        pop   = 1'b0;
        unique case (state)
            PH_IDLE: begin
                if (!empty) begin
                    pop   = 1'b1;
                    nxt   = PH_LOW;
                    cnt_n = lo_len;
                end
            end
            PH_LOW: begin
                if (cnt == DIV_W'(1)) begin
                    nxt   = PH_HIGH;
                    cnt_n = hi_q;
                end else begin
                    cnt_n = cnt - DIV_W'(1);
                end
            end
            PH_HIGH: begin
                if (cnt == DIV_W'(1)) begin
                    if (!empty) begin
                        pop   = 1'b1;
                        nxt   = PH_LOW;
                        cnt_n = lo_len;
                    end else begin
                        nxt   = PH_IDLE;
                        cnt_n = '0;
                    end
                end else begin
                    cnt_n = cnt - DIV_W'(1);
                end
            end
            default: begin
                nxt   = PH_IDLE;
                cnt_n = '0;
            end
        endcase
        hi_n = pop ? hi_len : hi_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PH_IDLE;
            cnt     <= '0;
            hi_q    <= '0;
            rx_data <= 1'b0;
            rx_clk  <= 1'b0;
        end else begin
            state  <= nxt;
            cnt    <= cnt_n;
            hi_q   <= hi_n;
            rx_clk <= (nxt == PH_HIGH) && !async_mode;
            if (pop) begin
                rx_data <= rd_bit;
            end
        end
    end

    // R4: clock is low whenever nothing is being played
    a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
        (state == PH_IDLE) |-> !rx_clk)
        else $error("clock high while idle");

    // R3: data does not move while the clock is high
    a_r3_data_stable: assert property (@(posedge clk) disable iff (rst)
        (state == PH_HIGH) |-> $stable(rx_data))
        else $error("data moved in high phase");

    // R6: asynchronous mode keeps the clock off
    a_r6_async_gate: assert property (@(posedge clk) disable iff (rst)
        async_mode |=> !rx_clk)
        else $error("clock active in async mode");

endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
    import rxeb_pkg::*;
#(
    parameter int DEPTH      = 32,
    parameter int CHUNK      = 3,
    parameter int DIV_W      = 8,
    parameter int MIN_DIV    = 4,
    parameter int WIN_MIN    = 256,
    parameter int WIN_SHIFTS = 3,
    parameter int DEADBAND   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             async_mode,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic             wr_valid,
    input  logic [CHUNK-1:0] wr_bits,
    output logic             rx_data,
    output logic             rx_clk
);
    localparam int FW = $clog2(DEPTH + 1);

    logic          pop;
    logic          rd_bit;
    logic [FW-1:0] fill;
    trim_t         trim;

    rxeb_fifo #(
        .DEPTH (DEPTH),
        .CHUNK (CHUNK),
        .FW    (FW)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_bits  (wr_bits),
        .pop      (pop),
        .rd_bit   (rd_bit),
        .fill     (fill)
    );

    rxeb_trim #(
        .DEPTH      (DEPTH),
        .FW         (FW),
        .WIN_MIN    (WIN_MIN),
        .WIN_SHIFTS (WIN_SHIFTS),
        .DEADBAND   (DEADBAND)
    ) u_trim (
        .clk       (clk),
        .rst       (rst),
        .bit_start (pop),
        .fill      (fill),
        .trim      (trim)
    );

    rxeb_playout #(
        .DIV_W   (DIV_W),
        .MIN_DIV (MIN_DIV)
    ) u_play (
        .clk        (clk),
        .rst        (rst),
        .async_mode (async_mode),
        .div_cfg    (div_cfg),
        .empty      (fill == '0),
        .rd_bit     (rd_bit),
        .trim       (trim),
        .pop        (pop),
        .rx_data    (rx_data),
        .rx_clk     (rx_clk)
    );

    // R1: one cycle after reset the clock output is low
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!rx_clk && !rx_data))
        else $error("outputs not cleared by reset");

endmodule

// File: tb/sim_rx_elastic_buf.sv
module sim_rx_elastic_buf;
    localparam int CLK_PERIOD = 10;
    localparam int TIMEOUT    = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       async_mode = 1'b0;
    logic [7:0] div_cfg = 8'd4;
    logic       wr_valid = 1'b0;
    logic [2:0] wr_bits = 3'b000;
    logic       rx_data;
    logic       rx_clk;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_elastic_buf u0 (
        .clk        (clk),
        .rst        (rst),
        .async_mode (async_mode),
        .div_cfg    (div_cfg),
        .wr_valid   (wr_valid),
        .wr_bits    (wr_bits),
        .rx_data    (rx_data),
        .rx_clk     (rx_clk)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit exp_q[$];
    int iv_idx[$];
    int iv_val[$];
    int edge_cnt = 0;
    int cyc = 0;
    int last_edge = 0;
    int last_iv = 0;
    int hi_run = 0;
    int hi_last = 0;
    int nominal = 4;
    bit track = 0;
    bit prev_clk = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    // monitor: scoreboard pop on each rising edge, interval and high-time capture
    always @(negedge clk) begin
        cyc++;
        if (rx_clk && !prev_clk) begin
            edge_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 edge with no bit", edge_cnt, 0);
            end else begin
                bit b;
                b = exp_q.pop_front();
                chk(rx_data == b, "R3 data order", int'(rx_data), int'(b));
            end
            if (edge_cnt >= 2) begin
                last_iv = cyc - last_edge;
                if (track && (last_iv != nominal)) begin
                    iv_idx.push_back(edge_cnt);
                    iv_val.push_back(last_iv);
                end
            end
            last_edge = cyc;
        end
        if (rx_clk) hi_run++;
        else if (prev_clk) begin
            hi_last = hi_run;
            hi_run  = 0;
        end
        prev_clk = rx_clk;
    end

    function automatic logic [2:0] rnd3();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[2:0];
    endfunction

    task automatic put(input logic [2:0] b, input bit expect_in);
        @(posedge clk);
        #1;
        wr_valid = 1'b1;
        wr_bits  = b;
        if (expect_in) begin
            for (int i = 0; i < 3; i++) exp_q.push_back(b[i]);
        end
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        wr_valid = 1'b0;
        exp_q.delete();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        edge_cnt = 0;
        track = 0;
        iv_idx.delete();
        iv_val.delete();
    endtask

    task automatic drain();
        for (int i = 0; i < 20000 && exp_q.size() != 0; i++) @(negedge clk);
        wr_valid = 1'b0;
        repeat (300) @(negedge clk);
    endtask

    // keep the scoreboard depth near a target until a given edge number
    task automatic run_fill(input int thresh, input int until_edge);
        while (edge_cnt < until_edge) begin
            if (exp_q.size() <= thresh) put(rnd3(), 1'b1);
            else idle();
        end
        idle();
    endtask

    initial begin
        repeat (TIMEOUT) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int e0;
        bit pat[9];
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(rx_clk == 1'b0, "R1 reset clock low", int'(rx_clk), 0);
        chk(rx_data == 1'b0, "R1 reset data low", int'(rx_data), 0);

        // R5: odd divisor 7 -> low 3, high 4, period 7
        div_cfg = 8'd7;
        for (int i = 0; i < 4; i++) put(rnd3(), 1'b1);
        idle();
        drain();
        chk(hi_last == 4, "R5 high time P=7", hi_last, 4);
        chk(last_iv == 7, "R5 period P=7", last_iv, 7);
        chk(exp_q.size() == 0, "R3 all bits played", exp_q.size(), 0);

        // R5: divisor below minimum is clamped to 4
        div_cfg = 8'd2;
        for (int i = 0; i < 3; i++) put(rnd3(), 1'b1);
        idle();
        drain();
        chk(last_iv == 4, "R5 clamp period", last_iv, 4);
        chk(hi_last == 2, "R5 clamp high time", hi_last, 2);

        // R4: gap with empty store, then resume
        e0 = edge_cnt;
        repeat (40) @(negedge clk);
        chk(edge_cnt == e0, "R4 no edge in gap", edge_cnt, e0);
        chk(rx_clk == 1'b0, "R4 clock low in gap", int'(rx_clk), 0);
        put(3'b110, 1'b1);
        idle();
        drain();
        chk(edge_cnt == e0 + 3, "R4 resume after gap", edge_cnt, e0 + 3);

        // R2: overflow, 13 back-to-back groups, only 11 fit
        do_reset();
        div_cfg = 8'd16;
        for (int i = 0; i < 13; i++) put(rnd3(), i < 11);
        idle();
        drain();
        chk(edge_cnt == 33, "R2 dropped groups", edge_cnt, 33);
        chk(exp_q.size() == 0, "R2 accepted groups played", exp_q.size(), 0);

        // R6: async mode, clock held off, data still flows
        do_reset();
        async_mode = 1'b1;
        div_cfg = 8'd8;
        pat = '{1, 0, 1, 1, 0, 0, 0, 1, 1};
        put(3'b101, 1'b0);
        put(3'b001, 1'b0);
        put(3'b110, 1'b0);
        idle();
        for (int i = 0; i < 200 && rx_data != 1'b1; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 9; k++) begin
            chk(rx_data == pat[k], "R6 async data", int'(rx_data), int'(pat[k]));
            if (k < 8) repeat (8) @(negedge clk);
        end
        repeat (40) @(negedge clk);
        chk(edge_cnt == 0, "R6 no clock edges", edge_cnt, 0);
        async_mode = 1'b0;

        // R7: low fill -> lengthen at edges 257 and 513
        do_reset();
        div_cfg = 8'd4;
        nominal = 4;
        track = 1;
        run_fill(5, 600);
        track = 0;
        drain();
        chk(iv_idx.size() == 2, "R7 lengthen count", iv_idx.size(), 2);
        if (iv_idx.size() >= 2) begin
            chk(iv_idx[0] == 257, "R7 first lengthen edge", iv_idx[0], 257);
            chk(iv_val[0] == 5, "R7 lengthened interval", iv_val[0], 5);
            chk(iv_idx[1] == 513, "R7 second lengthen edge", iv_idx[1], 513);
        end

        // R8: mid fill grows window to the cap, then high fill shortens
        do_reset();
        div_cfg = 8'd4;
        track = 1;
        run_fill(15, 4000);
        run_fill(27, 6200);
        track = 0;
        drain();
        chk(iv_idx.size() == 2, "R8 correction count", iv_idx.size(), 2);
        if (iv_idx.size() >= 2) begin
            chk(iv_idx[0] == 5889, "R8 capped window edge", iv_idx[0], 5889);
            chk(iv_val[0] == 3, "R7 shortened interval", iv_val[0], 3);
            chk(iv_idx[1] == 6145, "R8 window back to minimum", iv_idx[1], 6145);
        end

        // R1: reset in the middle of a full stream
        run_fill(27, 100);
        do_reset();
        repeat (60) @(negedge clk);
        chk(edge_cnt == 0, "R1 no edges after reset", edge_cnt, 0);
        chk(rx_clk == 1'b0, "R1 clock low after reset", int'(rx_clk), 0);
        put(3'b011, 1'b1);
        idle();
        drain();
        chk(edge_cnt == 3, "R1 clean restart", edge_cnt, 3);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule